// File: doc/BRIEF.md
# Address Watch Unit

The block compares each processor access against four programmable linear-address watch slots and asks for a debug exception when one of them matches. Each slot has an address register and, in a shared control register, a condition code and a span code. The condition code selects instruction fetches, data writes, or data reads and writes. The span code selects a 1, 2 or 4 byte window. Each slot has two enable bits, one local and one global, and it is armed when either bit is set.

Accesses arrive one per cycle as an address, a byte count and a kind. A match sets the slot's bit in a sticky status register on the clock edge that ends the access. The debug request follows one cycle later as a single-cycle pulse, so software always sees the status bit by the time the request arrives. Single-step and task-switch trap events come in as pulses and only set their own status bits. Status bits are cleared only when software writes the status register. Dispatching the exception is not part of this block.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset, every register index (0 to 5) reads 0 and `dbgReq` is low.
- R2: Register index 0 to 3 holds the watch address of slots 0 to 3, index 4 is the control register and index 5 is the status register. A write with `regWrEn` takes effect at the clock edge, and a read through `regAddr` returns the register value combinationally. Indexes 6 and 7 read 0.
- R3: In the control register, bit 2i is the local enable and bit 2i+1 is the global enable of slot i. A slot whose two enable bits are both 0 never matches.
- R4: The condition field of slot i is control bits [17+4i:16+4i]. Code 00 matches only a fetch (`accKind` 00), only when the span code is 00, and only when the access address equals the slot address exactly.
- R5: Condition code 01 matches only data writes (`accKind` 10). Condition code 11 matches data reads (`accKind` 01) and data writes, but never fetches.
- R6: The span field of slot i is control bits [19+4i:18+4i], with 00 for 1 byte, 01 for 2 bytes and 11 for 4 bytes. The watch window starts at the slot address with its low 0, 1 or 2 bits cleared. A data access of `accSize`+1 bytes matches when any byte it touches lies in the window.
- R7: Condition code 10, span code 10 and access kind 11 never produce a match.
- R8: Every slot that matches the same access sets its own status bit (bits 0 to 3) at the same edge.
- R9: Status bits are set at the clock edge that samples the matching access. `dbgReq` is high for exactly the next cycle, and only if at least one slot matched.
- R10: Hardware never clears a status bit. A software write to index 5 replaces the status with the written value, ORed with any event set at the same edge.
- R11: A `stepPulse` sets status bit 4 and a `taskTrapPulse` sets status bit 5. Neither raises `dbgReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | 32 | Access linear address |
| accSize | input | 2 | Access byte count minus one |
| accKind | input | 2 | 00 fetch, 01 read, 10 write, 11 reserved |
| stepPulse | input | 1 | Single-step trap event |
| taskTrapPulse | input | 1 | Trap-on-task-switch event |
| dbgReq | output | 1 | Debug exception request pulse |

## Verification
The bench goes after window edges. These are accesses that end on the byte just below an aligned window, and accesses that straddle into it from below. A design that checks only the start address, or that skips the alignment mask, misses the straddling hits or reports the near misses. Fetch slots are driven with a non-zero span and with addresses one byte off, which catches a comparator that treats fetches like data. The undefined codes, the reserved access kind and disabled slots are all exercised. So are several slots hitting one access, where a design that encodes priority instead of setting every bit would drop some of them. Status bits are polled across idle cycles to catch any clearing by hardware, and the request is sampled on both sides of its single cycle, which catches one that fires early or is held too long.

// File: rtl/addr_watch_pkg.sv
package addr_watch_pkg;
  localparam int AW_SLOTS    = 4;
  localparam int AW_ADDR_W   = 32;
  localparam int AW_DATA_W   = 32;
  localparam int AW_IDX_W    = 3;
  localparam int AW_STAT_W   = AW_SLOTS + 2;
  localparam int AW_COND_LSB = 16;
  localparam int AW_FIELD_STRIDE = 4;
  localparam int AW_IDX_CTL  = AW_SLOTS;
  localparam int AW_IDX_STAT = AW_SLOTS + 1;

  typedef enum logic [1:0] {
    COND_EXEC  = 2'b00,
    COND_WRITE = 2'b01,
    COND_UNDEF = 2'b10,
    COND_RW    = 2'b11
  } condKind_e;

  typedef enum logic [1:0] {
    SPAN_1     = 2'b00,
    SPAN_2     = 2'b01,
    SPAN_UNDEF = 2'b10,
    SPAN_4     = 2'b11
  } span_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_RSVD  = 2'b11
  } accKind_e;

  typedef struct packed {
    logic [AW_SLOTS-1:0]       addrWr;
    logic [AW_ADDR_W-1:0]      wrData;
    logic [AW_SLOTS-1:0]       active;
    logic [AW_SLOTS-1:0][1:0]  cond;
    logic [AW_SLOTS-1:0][1:0]  span;
  } ctrlStrobe_t;
endpackage

// File: rtl/aw_datapath.sv
module aw_datapath
  import addr_watch_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  ctrlStrobe_t                       strobe,
  input  logic                              accValid,
  input  logic [AW_ADDR_W-1:0]              accAddr,
  input  logic [1:0]                        accSize,
  input  logic [1:0]                        accKind,
  output logic [AW_SLOTS-1:0][AW_ADDR_W-1:0] slotAddr,
  output logic [AW_SLOTS-1:0]               hitVec
);
  localparam int EXT_W = AW_ADDR_W + 1;

  logic [EXT_W-1:0] accStart;
  logic [EXT_W-1:0] accEnd;

  assign accStart = {1'b0, accAddr};
  assign accEnd   = accStart + {{(EXT_W-2){1'b0}}, accSize};

  for (genvar i = 0; i < AW_SLOTS; i++) begin : g_slot
    logic [AW_ADDR_W-1:0] lowMask;
    logic [EXT_W-1:0]     winStart;
    logic [EXT_W-1:0]     winEnd;
    logic                 spanOk;
    logic                 overlap;
    logic                 kindOk;

    always_ff @(posedge clk) begin
      if (!rst_n) slotAddr[i] <= '0;
      else if (strobe.addrWr[i]) slotAddr[i] <= strobe.wrData;
    end

    always_comb begin
      unique case (strobe.span[i])
        SPAN_2:  lowMask = AW_ADDR_W'(1);
        SPAN_4:  lowMask = AW_ADDR_W'(3);
        default: lowMask = '0;
      endcase
      spanOk   = (strobe.span[i] != SPAN_UNDEF);
      winStart = {1'b0, slotAddr[i] & ~lowMask};
      winEnd   = winStart + {1'b0, lowMask};
      overlap  = (accStart <= winEnd) && (winStart <= accEnd);
      unique case (strobe.cond[i])
        COND_EXEC:  kindOk = (accKind == ACC_FETCH) && (strobe.span[i] == SPAN_1)
                             && (accAddr == slotAddr[i]);
        COND_WRITE: kindOk = (accKind == ACC_WRITE) && spanOk && overlap;
        COND_RW:    kindOk = ((accKind == ACC_READ) || (accKind == ACC_WRITE))
                             && spanOk && overlap;
        default:    kindOk = 1'b0;
      endcase
    end

    assign hitVec[i] = accValid && strobe.active[i] && kindOk;
  end
endmodule

// File: rtl/aw_ctrl.sv
module aw_ctrl
  import addr_watch_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               regWrEn,
  input  logic [AW_IDX_W-1:0]                regAddr,
  input  logic [AW_DATA_W-1:0]               regWrData,
  output logic [AW_DATA_W-1:0]               regRdData,
  input  logic                               stepPulse,
  input  logic                               taskTrapPulse,
  input  logic [AW_SLOTS-1:0][AW_ADDR_W-1:0] slotAddr,
  input  logic [AW_SLOTS-1:0]                hitVec,
  output ctrlStrobe_t                        strobe,
  output logic                               dbgReq
);
  localparam int SLOT_IDX_W = $clog2(AW_SLOTS);

  logic [AW_DATA_W-1:0] ctlReg;
  logic [AW_STAT_W-1:0] statReg;
  logic [AW_STAT_W-1:0] statNext;
  logic                 reqStage;
  logic                 wrCtl;
  logic                 wrStat;

  assign wrCtl  = regWrEn && (regAddr == AW_IDX_W'(AW_IDX_CTL));
  assign wrStat = regWrEn && (regAddr == AW_IDX_W'(AW_IDX_STAT));

  always_comb begin
    strobe.wrData = regWrData;
    for (int i = 0; i < AW_SLOTS; i++) begin
      strobe.addrWr[i] = regWrEn && (regAddr == AW_IDX_W'(i));
      strobe.active[i] = ctlReg[2*i] | ctlReg[2*i+1];
      strobe.cond[i]   = ctlReg[AW_COND_LSB + AW_FIELD_STRIDE*i +: 2];
      strobe.span[i]   = ctlReg[AW_COND_LSB + AW_FIELD_STRIDE*i + 2 +: 2];
    end
  end

  always_comb begin
    statNext = wrStat ? regWrData[AW_STAT_W-1:0] : statReg;
    statNext = statNext | {taskTrapPulse, stepPulse, hitVec};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlReg   <= '0;
      statReg  <= '0;
      reqStage <= 1'b0;
      dbgReq   <= 1'b0;
    end else begin
      if (wrCtl) ctlReg <= regWrData;
      statReg  <= statNext;
      reqStage <= |hitVec;
      dbgReq   <= reqStage;
    end
  end

  always_comb begin
    if (regAddr < AW_IDX_W'(AW_SLOTS))
      regRdData = slotAddr[regAddr[SLOT_IDX_W-1:0]];
    else if (regAddr == AW_IDX_W'(AW_IDX_CTL))
      regRdData = ctlReg;
    else if (regAddr == AW_IDX_W'(AW_IDX_STAT))
      regRdData = {{(AW_DATA_W-AW_STAT_W){1'b0}}, statReg};
    else
      regRdData = '0;
  end

  AST_HIT_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hitVec & ~strobe.active) == '0); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wrStat |=> ((statReg & $past(statReg)) == $past(statReg))); // R10

  AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    |hitVec |=> ((statReg[AW_SLOTS-1:0] & $past(hitVec)) == $past(hitVec))); // R8

  AST_REQ_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    |hitVec |=> ##1 dbgReq); // R9

  AST_REQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    dbgReq |-> $past(|hitVec, 2)); // R9

  for (genvar i = 0; i < AW_SLOTS; i++) begin : g_undef_chk
    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((strobe.cond[i] == COND_UNDEF) || (strobe.span[i] == SPAN_UNDEF))
        |-> !hitVec[i]); // R7
  end
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import addr_watch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  regWrEn,
  input  logic [AW_IDX_W-1:0]   regAddr,
  input  logic [AW_DATA_W-1:0]  regWrData,
  output logic [AW_DATA_W-1:0]  regRdData,
  input  logic                  accValid,
  input  logic [AW_ADDR_W-1:0]  accAddr,
  input  logic [1:0]            accSize,
  input  logic [1:0]            accKind,
  input  logic                  stepPulse,
  input  logic                  taskTrapPulse,
  output logic                  dbgReq
);
  ctrlStrobe_t                        strobe;
  logic [AW_SLOTS-1:0][AW_ADDR_W-1:0] slotAddr;
  logic [AW_SLOTS-1:0]                hitVec;

  aw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData),
    .stepPulse(stepPulse), .taskTrapPulse(taskTrapPulse),
    .slotAddr(slotAddr), .hitVec(hitVec),
    .strobe(strobe), .dbgReq(dbgReq)
  );

  aw_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .accValid(accValid), .accAddr(accAddr), .accSize(accSize),
    .accKind(accKind), .slotAddr(slotAddr), .hitVec(hitVec)
  );
endmodule

// File: tb/tb_addr_watch_unit.sv
module tb_addr_watch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic [1:0]  accKind = '0;
  logic        stepPulse = 1'b0;
  logic        taskTrapPulse = 1'b0;
  logic        dbgReq;

  int checks = 0;
  int errors = 0;
  logic [31:0] mAddr [4];
  logic [31:0] mCtl = '0;
  logic [5:0]  mStat = '0;

  always #4 clk = ~clk;

  addr_watch_unit dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .accValid(accValid),
    .accAddr(accAddr), .accSize(accSize), .accKind(accKind),
    .stepPulse(stepPulse), .taskTrapPulse(taskTrapPulse), .dbgReq(dbgReq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  function automatic bit refHit(int s, logic [31:0] a, logic [1:0] sz, logic [1:0] k);
    logic [1:0] cnd = mCtl[16+4*s +: 2];
    logic [1:0] spn = mCtl[18+4*s +: 2];
    longint len, base, b;
    if (!(mCtl[2*s] || mCtl[2*s+1])) return 0;
    if (cnd == 2'b10 || spn == 2'b10 || k == 2'b11) return 0;
    if (cnd == 2'b00) return (k == 2'b00) && (spn == 2'b00) && (a == mAddr[s]);
    if (cnd == 2'b01 && k != 2'b10) return 0;
    if (cnd == 2'b11 && k == 2'b00) return 0;
    len  = (spn == 2'b00) ? 1 : (spn == 2'b01) ? 2 : 4;
    base = longint'(mAddr[s]) - (longint'(mAddr[s]) % len);
    for (int i = 0; i <= int'(sz); i++) begin
      b = longint'(a) + i;
      if (b >= base && b < base + len) return 1;
    end
    return 0;
  endfunction

  task automatic wrReg(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = idx; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    if (idx < 4) mAddr[idx] = d;
    else if (idx == 4) mCtl = d;
    else if (idx == 5) mStat = d[5:0];
  endtask

  task automatic readChk(string tag, logic [2:0] idx, logic [31:0] exp);
    regAddr = idx; #1;
    check(tag, regRdData, exp);
  endtask

  task automatic doAccess(string tag, logic [31:0] a, logic [1:0] sz, logic [1:0] k);
    logic [3:0] exp;
    for (int s = 0; s < 4; s++) exp[s] = refHit(s, a, sz, k);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accSize = sz; accKind = k;
    @(posedge clk); #1;
    accValid = 1'b0;
    mStat = mStat | {2'b00, exp};
    readChk({tag, " status"}, 3'd5, {26'd0, mStat});
    check({tag, " R9 req early"}, {31'd0, dbgReq}, 32'd0);
    @(posedge clk); #1;
    check({tag, " R9 req"}, {31'd0, dbgReq}, {31'd0, |exp});
    @(posedge clk); #1;
    check({tag, " R9 req drop"}, {31'd0, dbgReq}, 32'd0);
  endtask

  function automatic logic [31:0] fld(int s, logic [1:0] c, logic [1:0] sp);
    return ({28'd0, sp, c} << (16 + 4*s));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act %0d exp %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mAddr[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 6; i++) readChk("R1 reset reg", 3'(i), 32'd0);
    check("R1 dbgReq", {31'd0, dbgReq}, 32'd0);

    // R2 register access
    wrReg(3'd0, 32'h0000_0100); wrReg(3'd1, 32'h0000_0203);
    wrReg(3'd2, 32'hDEAD_BEEF); wrReg(3'd3, 32'h1234_5678);
    for (int i = 0; i < 4; i++) readChk("R2 slot addr", 3'(i), mAddr[i]);
    wrReg(3'd4, 32'h00F0_0000);
    readChk("R2 ctl", 3'd4, 32'h00F0_0000);
    readChk("R2 idx6", 3'd6, 32'd0);
    readChk("R2 idx7", 3'd7, 32'd0);

    // R4 fetch slot 0, local enable
    wrReg(3'd4, 32'h1 | fld(0, 2'b00, 2'b00));
    doAccess("R4 fetch exact", 32'h100, 2'd0, 2'b00);
    readChk("R4 bit0 set", 3'd5, 32'h1);
    wrReg(3'd5, 32'h0);
    doAccess("R4 fetch off by one", 32'h101, 2'd0, 2'b00);
    doAccess("R4 read at fetch addr", 32'h100, 2'd0, 2'b01);
    wrReg(3'd4, 32'h1 | fld(0, 2'b00, 2'b01));
    doAccess("R4 fetch wide span", 32'h100, 2'd0, 2'b00);

    // R5/R6 slot 1, global enable, write-only, 4 byte window at 0x200
    wrReg(3'd4, 32'h8 | fld(1, 2'b01, 2'b11));
    doAccess("R6 write aligned", 32'h200, 2'd0, 2'b10);
    readChk("R6 bit1", 3'd5, 32'h2);
    wrReg(3'd5, 32'h0);
    doAccess("R5 read on write slot", 32'h200, 2'd0, 2'b01);
    doAccess("R6 below window", 32'h1FE, 2'd1, 2'b10);
    doAccess("R6 straddle in", 32'h1FF, 2'd1, 2'b10);
    wrReg(3'd5, 32'h0);
    doAccess("R6 above window", 32'h204, 2'd3, 2'b10);
    wrReg(3'd4, 32'h8 | fld(1, 2'b11, 2'b01));
    doAccess("R5 read rw slot", 32'h202, 2'd0, 2'b01);
    doAccess("R5 fetch rw slot", 32'h202, 2'd0, 2'b00);
    wrReg(3'd5, 32'h0);

    // R7 undefined codes and reserved kind
    wrReg(3'd4, 32'h8 | fld(1, 2'b10, 2'b00));
    doAccess("R7 undef cond", 32'h203, 2'd0, 2'b10);
    wrReg(3'd4, 32'h8 | fld(1, 2'b11, 2'b10));
    doAccess("R7 undef span", 32'h203, 2'd0, 2'b10);
    wrReg(3'd4, 32'h8 | fld(1, 2'b11, 2'b00));
    doAccess("R7 rsvd kind", 32'h203, 2'd0, 2'b11);
    readChk("R7 status clear", 3'd5, 32'h0);

    // R3 disabled slot
    wrReg(3'd4, fld(1, 2'b11, 2'b00));
    doAccess("R3 disabled", 32'h203, 2'd0, 2'b10);

    // R8 all slots at once
    for (int i = 0; i < 4; i++) wrReg(3'(i), 32'h300);
    wrReg(3'd4, 32'hA5 | fld(0,2'b11,2'b00) | fld(1,2'b11,2'b00)
                       | fld(2,2'b11,2'b00) | fld(3,2'b11,2'b00));
    doAccess("R8 multi", 32'h300, 2'd0, 2'b01);
    readChk("R8 all bits", 3'd5, 32'hF);

    // R10 stickiness and software clear
    repeat (5) @(posedge clk);
    #1 readChk("R10 sticky", 3'd5, 32'hF);
    doAccess("R10 miss keeps", 32'h400, 2'd0, 2'b01);
    wrReg(3'd5, 32'h0);
    readChk("R10 sw clear", 3'd5, 32'h0);

    // R11 pulses
    @(negedge clk); stepPulse = 1'b1;
    @(posedge clk); #1 stepPulse = 1'b0;
    readChk("R11 step bit", 3'd5, 32'h10);
    @(negedge clk); taskTrapPulse = 1'b1;
    @(posedge clk); #1 taskTrapPulse = 1'b0;
    readChk("R11 task bit", 3'd5, 32'h30);
    @(posedge clk); #1 check("R11 no req", {31'd0, dbgReq}, 32'd0);
    @(posedge clk); #1 check("R11 no req late", {31'd0, dbgReq}, 32'd0);
    mStat = 6'h30;

    // random mix, R6 R5 R8
    void'($urandom(32'd2024));
    for (int it = 0; it < 300; it++) begin
      if (it % 10 == 0) begin
        for (int s = 0; s < 4; s++) wrReg(3'(s), 32'h1000_0000 | ($urandom % 64));
        wrReg(3'd4, $urandom);
      end
      wrReg(3'd5, 32'h0);
      doAccess("R6 random", 32'h1000_0000 | ($urandom % 64),
               2'($urandom % 4), 2'($urandom % 4));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule